// File: doc/BRIEF.md
# IEC 958 Compressed-Audio Burst Transmitter

This block drives a single biphase-mark-coded serial line in the IEC 958 consumer style. It has two modes. In PCM mode each frame carries one 16-bit left sample and one 16-bit right sample. In data mode the line carries non-PCM bitstreams packed into bursts. Each burst opens with four 16-bit header words: two fixed sync words, an info word, and a length word. The payload words follow, and the burst is then padded with zero words until a programmed repetition period, counted in frames, has elapsed. In data mode each frame carries 32 bits of burst data, one 16-bit word in each subframe.

The half-cell rate is derived from a clock enable that pulses at 256, 384 or 512 times the sample rate. Burst payload words arrive on a valid/ready stream. PCM pairs are taken from two sample inputs, which the block captures with a one-cycle strobe. The channel-status bits come from a 192-bit vector that is indexed by the frame position inside the 192-frame block.

Top module: `spdif_burst_tx`

## Requirements
- R1: The half-cell tick rate is the `clk_en` rate divided by 2, 3 or 4 for `ratio_sel` values 0, 1 and 2/3 (256, 384 and 512 times fs), so one frame lasts 128 half-cells.
- R2: Outside reset, every slot from 4 to 31 begins with a level change, and a bit of 1 adds a second change in the middle of the slot. The line is low during reset and is low again at every subframe boundary.
- R3: Slots 0–3 carry an 8-half-cell preamble that starts with a transition. Its patterns, written for a preceding low level, are 11101000 for the first channel-1 subframe of each 192-frame block, 11100010 for every other channel-1 subframe, and 11100100 for channel 2.
- R4: Slots 4–11 and slot 29 (user) are zero. Slots 12–27 carry the 16-bit word with the LSB first, slot 28 is validity, and slot 31 makes the count of ones over slots 4–31 even.
- R5: Slot 30 of both subframes of frame f carries `cs_bits[f]`. In data mode bit index 1 is forced to 1, which is the non-audio flag.
- R6: In PCM mode the pair is captured at the start of each channel-1 subframe, and `pcm_take` pulses in that same cycle. `pcm_left` goes into channel 1 and `pcm_right` goes into channel 2, with validity 0.
- R7: In data mode validity is 1. A burst starts on a channel-1 subframe, and its first four words are 0xF872, 0x4E1F, the info word {stream[2:0], 8'h00, type[4:0]} and the payload length in bits.
- R8: Next come ceil(len/16) payload words, taken in stream order at one word per subframe. `word_ready` pulses only in the cycle a word is consumed.
- R9: The burst occupies 2·rep_frames words, padded with zero words after the payload, and the next burst starts right after. A period below 2 frames counts as 2. A payload longer than the period is cut off at the period.
- R10: A payload word that is due while `word_valid` is low is sent as zero and still counts toward the payload.
- R11: Type, stream, length and period are sampled when the burst starts. Changes made during a burst first affect the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Audio clock enable at 256, 384 or 512 fs |
| ratio_sel | input | 2 | Divider: 0 = /2, 1 = /3, 2 or 3 = /4 |
| data_mode | input | 1 | 1 = burst data, 0 = two-channel PCM; sampled per frame |
| burst_type | input | 5 | Data type field of the info word |
| burst_stream | input | 3 | Bitstream number field of the info word |
| burst_len | input | 16 | Payload length in bits |
| rep_frames | input | REP_W | Burst repetition period in frames |
| word_data | input | 16 | Payload word from the stream |
| word_valid | input | 1 | Payload word available |
| word_ready | output | 1 | Payload word consumed this cycle |
| pcm_left | input | 16 | Channel-1 PCM sample |
| pcm_right | input | 16 | Channel-2 PCM sample |
| pcm_take | output | 1 | PCM pair captured this cycle |
| cs_bits | input | FRAMES | Channel-status bits, one per frame of a block |
| spdif_out | output | 1 | Biphase-mark-coded serial line |

## Verification
Assertions check several properties on every cycle. The line changes only on half-cell ticks and is low at each subframe load. Ticks never come on back-to-back cycles. A burst header always lands on a channel-1 subframe, the word counter stays inside the period, and `word_ready` never stays high for two cycles. Word content can only be shown by the bench scenarios, which decode the line back into preambles and slots. These scenarios cover PCM sample order across a 192-frame block wrap, the header and payload ordering, zero stuffing, underrun, the clamp on the period, truncation, late header changes and all three divider ratios.

// File: rtl/iec_tx_pkg.sv
// Shared constants and types for the IEC 958 burst transmitter.
// Assumes 32 time slots per subframe and two half-cells per slot.
package iec_tx_pkg;
    localparam int HALF_CELLS = 64;
    localparam int PRE_HC     = 8;

    localparam logic [15:0] SYNC_A = 16'hF872;
    localparam logic [15:0] SYNC_B = 16'h4E1F;

    // Preamble half-cell patterns for a preceding low level, first half-cell in bit 7
    localparam logic [7:0] PAT_B = 8'b11101000;
    localparam logic [7:0] PAT_M = 8'b11100010;
    localparam logic [7:0] PAT_W = 8'b11100100;

    // Word offered to the line coder for the subframe being loaded
    typedef struct packed {
        logic [15:0] word;
        logic        vbit;
        logic        data;
    } slot_word_t;
endpackage

// File: rtl/iec_tick_gen.sv
// Half-cell tick generator: divides the audio clock enable by 2, 3 or 4.
// Assumes clk_en pulses at 256, 384 or 512 times the sample rate.
module iec_tick_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic [1:0] ratio_sel,
    output logic       hc_tick
);
    localparam int CW = 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Pick the terminal count from the ratio setting
    always_comb begin
        case (ratio_sel)
            2'd0:    lim = CW'(1);
            2'd1:    lim = CW'(2);
            default: lim = CW'(3);
        endcase
        hc_tick = clk_en && (cnt_q >= lim);
    end

    // Count enable pulses, wrap at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clk_en)
            cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hc_tick |=> !hc_tick);
endmodule

// File: rtl/iec_burst_seq.sv
// Burst sequencer: picks the 16-bit word for each subframe load.
// In data mode it walks header, payload and stuffing words. In PCM mode it
// captures the sample pair. Assumes load pulses once per subframe with
// ch2_next naming the subframe being loaded.
module iec_burst_seq
    import iec_tx_pkg::*;
#(
    parameter int REP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ch2_next,
    input  logic             data_mode,
    input  logic [4:0]       burst_type,
    input  logic [2:0]       burst_stream,
    input  logic [15:0]      burst_len,
    input  logic [REP_W-1:0] rep_frames,
    input  logic [15:0]      word_data,
    input  logic             word_valid,
    output logic             word_ready,
    input  logic [15:0]      pcm_left,
    input  logic [15:0]      pcm_right,
    output logic             pcm_take,
    output slot_word_t       slot
);
    localparam int CW   = REP_W + 1;
    localparam int PW_W = 13;
    localparam int XW   = ((CW > PW_W) ? CW : PW_W) + 1;

    logic             mode_q;
    logic [CW-1:0]    wc_q, nw_q, eff, nw_cur, nw_in;
    logic [PW_W-1:0]  pw_q, pw_in, pw_cur;
    logic [15:0]      pc_q, pd_q, pc_in, pc_cur, pd_cur;
    logic [15:0]      pcm_r_q, dword;
    logic [REP_W-1:0] rep_eff;
    logic [16:0]      len_round;
    logic             cur_data, restart, at_head, in_pay;

    // Resolve mode, burst position and header fields for this load
    always_comb begin
        cur_data  = ch2_next ? mode_q : data_mode;
        restart   = !ch2_next && data_mode && !mode_q;
        eff       = restart ? '0 : wc_q;
        at_head   = (eff == '0);
        rep_eff   = (rep_frames < REP_W'(2)) ? REP_W'(2) : rep_frames;
        nw_in     = {rep_eff, 1'b0};
        len_round = {1'b0, burst_len} + 17'd15;
        pw_in     = len_round[16:4];
        pc_in     = {burst_stream, 8'h00, burst_type};
        nw_cur    = at_head ? nw_in : nw_q;
        pw_cur    = at_head ? pw_in : pw_q;
        pc_cur    = at_head ? pc_in : pc_q;
        pd_cur    = at_head ? burst_len : pd_q;
        in_pay    = (XW'(eff) >= XW'(4)) && (XW'(eff) < XW'(pw_cur) + XW'(4));
    end

    // Choose the burst word for the current position
    always_comb begin
        if (eff == CW'(0))      dword = SYNC_A;
        else if (eff == CW'(1)) dword = SYNC_B;
        else if (eff == CW'(2)) dword = pc_cur;
        else if (eff == CW'(3)) dword = pd_cur;
        else if (in_pay)        dword = word_valid ? word_data : 16'h0000;
        else                    dword = 16'h0000;
    end

    // Handshakes and the word handed to the line coder
    always_comb begin
        word_ready = load && cur_data && in_pay;
        pcm_take   = load && !cur_data && !ch2_next;
        slot.word  = cur_data ? dword : (ch2_next ? pcm_r_q : pcm_left);
        slot.vbit  = cur_data;
        slot.data  = cur_data;
    end

    // Advance the burst counter and latch header fields at burst start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            wc_q    <= '0;
            nw_q    <= '0;
            pw_q    <= '0;
            pc_q    <= '0;
            pd_q    <= '0;
            pcm_r_q <= '0;
        end else if (load) begin
            if (!ch2_next)
                mode_q <= data_mode;
            if (cur_data) begin
                wc_q <= (eff == nw_cur - CW'(1)) ? '0 : eff + CW'(1);
                if (at_head) begin
                    nw_q <= nw_in;
                    pw_q <= pw_in;
                    pc_q <= pc_in;
                    pd_q <= burst_len;
                end
            end else begin
                wc_q <= '0;
            end
            if (pcm_take)
                pcm_r_q <= pcm_right;
        end
    end

    // R7
    head_on_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cur_data && at_head) |-> !ch2_next);

    // R8
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |=> !word_ready);

    // R9
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cur_data) |-> (eff < nw_cur));
endmodule

// File: rtl/iec_bmc_line.sv
// Line coder: tracks half-cell, subframe and frame position. It builds each
// subframe (preamble, aux, word, V, U, C, parity) and drives the biphase-mark line.
// Assumes hc_tick marks half-cell boundaries and the line starts low.
module iec_bmc_line
    import iec_tx_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hc_tick,
    input  slot_word_t        slot,
    input  logic [FRAMES-1:0] cs_bits,
    output logic              load,
    output logic              ch2_next,
    output logic              line
);
    localparam int FW  = $clog2(FRAMES);
    localparam int HCW = $clog2(HALF_CELLS);

    logic [HCW-1:0] hc_q, pos;
    logic           sub_q, inv_q, line_q, cbit;
    logic [FW-1:0]  frame_q, frame_next;
    logic [31:0]    body, sf_q;
    logic [7:0]     pat_n, pat_q;

    // Position bookkeeping and next-subframe assembly
    always_comb begin
        load       = hc_tick && (hc_q == HCW'(HALF_CELLS - 1));
        ch2_next   = !sub_q;
        frame_next = frame_q;
        if (sub_q)
            frame_next = (frame_q == FW'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
        cbit       = cs_bits[frame_next] | (slot.data && (frame_next == FW'(1)));
        body       = '0;
        body[27:12] = slot.word;
        body[28]   = slot.vbit;
        body[30]   = cbit;
        body[31]   = ^body[30:4];
        pat_n      = ch2_next ? PAT_W : ((frame_next == '0) ? PAT_B : PAT_M);
        pos        = load ? '0 : hc_q + 1'b1;
    end

    // Step position, load subframes and encode one half-cell per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q    <= '1;
            sub_q   <= 1'b1;
            frame_q <= FW'(FRAMES - 1);
            sf_q    <= '0;
            pat_q   <= '0;
            inv_q   <= 1'b0;
            line_q  <= 1'b0;
        end else if (hc_tick) begin
            hc_q <= pos;
            if (load) begin
                sub_q   <= ~sub_q;
                frame_q <= frame_next;
                sf_q    <= body;
                pat_q   <= pat_n;
                inv_q   <= line_q;
            end
            if (pos < HCW'(PRE_HC))
                line_q <= load ? (pat_n[7] ^ line_q) : (pat_q[~pos[2:0]] ^ inv_q);
            else if (!pos[0])
                line_q <= ~line_q;
            else if (sf_q[pos[HCW-1:1]])
                line_q <= ~line_q;
        end
    end

    assign line = line_q;

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hc_tick |=> $stable(line));

    // R2
    boundary_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !line);
endmodule

// File: rtl/spdif_burst_tx.sv
// Top: IEC 958 transmitter for two-channel PCM or non-PCM data bursts.
// Ties together the half-cell divider, the burst sequencer and the line coder.
module spdif_burst_tx
    import iec_tx_pkg::*;
#(
    parameter int REP_W  = 12,
    parameter int FRAMES = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [1:0]        ratio_sel,
    input  logic              data_mode,
    input  logic [4:0]        burst_type,
    input  logic [2:0]        burst_stream,
    input  logic [15:0]       burst_len,
    input  logic [REP_W-1:0]  rep_frames,
    input  logic [15:0]       word_data,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [15:0]       pcm_left,
    input  logic [15:0]       pcm_right,
    output logic              pcm_take,
    input  logic [FRAMES-1:0] cs_bits,
    output logic              spdif_out
);
    logic       hc_tick, load, ch2_next;
    slot_word_t slot;

    iec_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ratio_sel (ratio_sel),
        .hc_tick   (hc_tick)
    );

    iec_burst_seq #(.REP_W(REP_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .ch2_next     (ch2_next),
        .data_mode    (data_mode),
        .burst_type   (burst_type),
        .burst_stream (burst_stream),
        .burst_len    (burst_len),
        .rep_frames   (rep_frames),
        .word_data    (word_data),
        .word_valid   (word_valid),
        .word_ready   (word_ready),
        .pcm_left     (pcm_left),
        .pcm_right    (pcm_right),
        .pcm_take     (pcm_take),
        .slot         (slot)
    );

    iec_bmc_line #(.FRAMES(FRAMES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .hc_tick  (hc_tick),
        .slot     (slot),
        .cs_bits  (cs_bits),
        .load     (load),
        .ch2_next (ch2_next),
        .line     (spdif_out)
    );
endmodule

// File: tb/sim_spdif_burst_tx.sv
`timescale 1ns/1ps
module sim_spdif_burst_tx;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b1;
    logic [1:0]   ratio_sel = 2'd0;
    logic         data_mode = 1'b0;
    logic [4:0]   burst_type = '0;
    logic [2:0]   burst_stream = '0;
    logic [15:0]  burst_len = '0;
    logic [11:0]  rep_frames = '0;
    logic [15:0]  word_data;
    logic         word_valid;
    logic         word_ready;
    logic [15:0]  pcm_left, pcm_right;
    logic         pcm_take;
    logic [191:0] cs_bits;
    logic         spdif_out;
    logic         src_en = 1'b1;
    int           widx, pidx;
    int           vectors = 0;
    int           fails = 0;

    typedef struct {
        logic [1:0]  pre;
        logic [15:0] word;
        logic        v;
        logic        c;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    spdif_burst_tx u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ratio_sel(ratio_sel),
        .data_mode(data_mode), .burst_type(burst_type), .burst_stream(burst_stream),
        .burst_len(burst_len), .rep_frames(rep_frames), .word_data(word_data),
        .word_valid(word_valid), .word_ready(word_ready), .pcm_left(pcm_left),
        .pcm_right(pcm_right), .pcm_take(pcm_take), .cs_bits(cs_bits),
        .spdif_out(spdif_out)
    );

    function automatic logic [15:0] pay_val(int i);
        return 16'hA5C3 ^ 16'(i * 263);
    endfunction
    function automatic logic [15:0] pcm_l_val(int i);
        return 16'h1234 + 16'(i * 801);
    endfunction
    function automatic logic [15:0] pcm_r_val(int i);
        return 16'hFEDC - 16'(i * 531);
    endfunction

    assign word_valid = src_en;
    assign word_data  = pay_val(widx);
    assign pcm_left   = pcm_l_val(pidx);
    assign pcm_right  = pcm_r_val(pidx);

    // stream and PCM sources advance on their handshakes
    always @(posedge clk) begin
        if (!rst_n) begin
            widx <= 0;
            pidx <= 0;
        end else begin
            if (word_valid && word_ready) widx <= widx + 1;
            if (pcm_take) pidx <= pidx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        exp_q.delete();
        rst_n = 1'b1;
    endtask

    function automatic logic exp_c(int f, bit dm);
        int fi = f % 192;
        return (fi == 1 && dm) ? 1'b1 : cs_bits[fi];
    endfunction

    function automatic logic [1:0] exp_pre(int n);
        if (n % 2 == 1) return 2'd2;
        return ((n / 2) % 192 == 0) ? 2'd0 : 2'd1;
    endfunction

    // driver: expected subframes for PCM mode
    task automatic push_lpcm(input int frames);
        exp_t it;
        for (int n = 0; n < 2 * frames; n++) begin
            it.pre  = exp_pre(n);
            it.word = (n % 2 == 0) ? pcm_l_val(n / 2) : pcm_r_val(n / 2);
            it.v    = 1'b0;
            it.c    = exp_c(n / 2, 1'b0);
            it.req  = "R6";
            exp_q.push_back(it);
        end
    endtask

    // driver: expected subframes for data mode
    task automatic push_data(input int frames, input int rep, input int len0, input int len1,
                             input logic [4:0] t0, input logic [4:0] t1, input logic [2:0] st,
                             input bit src_on, input string hdr_req);
        exp_t it;
        int nw = 2 * ((rep < 2) ? 2 : rep);
        int pm = 0;
        for (int n = 0; n < 2 * frames; n++) begin
            int b   = n / nw;
            int e   = n % nw;
            int len = (b == 0) ? len0 : len1;
            logic [4:0] t = (b == 0) ? t0 : t1;
            int pw  = (len + 15) / 16;
            it.pre = exp_pre(n);
            it.v   = 1'b1;
            it.c   = exp_c(n / 2, 1'b1);
            if (e == 0)      begin it.word = 16'hF872; it.req = "R7"; end
            else if (e == 1) begin it.word = 16'h4E1F; it.req = "R7"; end
            else if (e == 2) begin it.word = {st, 8'h00, t}; it.req = (b > 0) ? hdr_req : "R7"; end
            else if (e == 3) begin it.word = 16'(len); it.req = (b > 0) ? hdr_req : "R7"; end
            else if (e < 4 + pw) begin
                if (src_on) begin it.word = pay_val(pm); pm++; it.req = "R8"; end
                else begin it.word = 16'h0000; it.req = "R10"; end
            end else begin it.word = 16'h0000; it.req = "R9"; end
            exp_q.push_back(it);
        end
    endtask

    // monitor: decode the line half-cell by half-cell and compare with the queue
    task automatic run_mon(input int nsub, input int hp);
        logic        h[64];
        logic [31:0] b;
        logic [7:0]  p8, pe;
        logic        inv;
        bit          bmc_ok;
        exp_t        e;
        @(posedge spdif_out);
        @(negedge clk);
        for (int s = 0; s < nsub; s++) begin
            for (int k = 0; k < 64; k++) begin
                if (!(s == 0 && k == 0)) repeat (hp) @(negedge clk);
                h[k] = spdif_out;
            end
            inv = !h[0];
            for (int k = 0; k < 8; k++) p8[7-k] = h[k] ^ inv;
            b = '0;
            bmc_ok = 1'b1;
            for (int t = 4; t < 32; t++) begin
                b[t] = h[2*t] ^ h[2*t+1];
                if (h[2*t] == h[2*t-1]) bmc_ok = 1'b0;
            end
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", 32'(s), 32'(nsub));
            end else begin
                e = exp_q.pop_front();
                pe = (e.pre == 2'd0) ? 8'b11101000 : (e.pre == 2'd1) ? 8'b11100010 : 8'b11100100;
                chk(h[0] == 1'b1, "R2", 32'(h[0]), 32'd1);
                chk(bmc_ok, "R2", 32'(bmc_ok), 32'd1);
                chk(p8 == pe, "R3", 32'(p8), 32'(pe));
                chk(b[11:4] == 8'h00, "R4", 32'(b[11:4]), 32'd0);
                chk(b[29] == 1'b0, "R4", 32'(b[29]), 32'd0);
                chk((^b[31:4]) == 1'b0, "R4", 32'(b[31:4]), 32'd0);
                chk(b[27:12] == e.word, e.req, 32'(b[27:12]), 32'(e.word));
                chk(b[28] == e.v, e.req, 32'(b[28]), 32'(e.v));
                chk(b[30] == e.c, "R5", 32'(b[30]), 32'(e.c));
            end
        end
    endtask

    // R1: length of the opening high run (three half-cells of the first preamble)
    task automatic measure(input logic [1:0] r, input int expn);
        int n = 0;
        ratio_sel = r;
        do_reset();
        @(posedge spdif_out);
        while (spdif_out) begin
            @(negedge clk);
            if (spdif_out) n++;
        end
        chk(n == expn, "R1", 32'(n), 32'(expn));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        for (int i = 0; i < 192; i++) cs_bits[i] = (i % 3 == 0) || (i % 7 == 2);
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(spdif_out == 1'b0, "R2", 32'(spdif_out), 32'd0);
        chk(word_ready == 1'b0, "R8", 32'(word_ready), 32'd0);
        chk(pcm_take == 1'b0, "R6", 32'(pcm_take), 32'd0);

        // R1: divider ratios
        measure(2'd0, 6);
        measure(2'd1, 9);
        measure(2'd2, 12);

        // R6, R5, R3: PCM across a block wrap
        ratio_sel = 2'd0;
        data_mode = 1'b0;
        do_reset();
        push_lpcm(194);
        run_mon(388, 2);

        // R7, R8, R9, R11: bursts with a header change during the first burst
        data_mode = 1'b1; rep_frames = 12'd8; burst_len = 16'd64;
        burst_type = 5'h0B; burst_stream = 3'd5;
        do_reset();
        push_data(24, 8, 64, 48, 5'h0B, 5'h11, 3'd5, 1'b1, "R11");
        fork
            run_mon(48, 2);
            begin
                repeat (800) @(negedge clk);
                burst_len = 16'd48;
                burst_type = 5'h11;
            end
        join

        // R10: source withholds data
        src_en = 1'b0; rep_frames = 12'd6; burst_len = 16'd40;
        burst_type = 5'h03; burst_stream = 3'd2;
        do_reset();
        push_data(12, 6, 40, 40, 5'h03, 5'h03, 3'd2, 1'b0, "R7");
        run_mon(24, 2);
        src_en = 1'b1;

        // R9: period below two frames clamps to two, empty payload
        rep_frames = 12'd1; burst_len = 16'd0;
        do_reset();
        push_data(4, 1, 0, 0, 5'h03, 5'h03, 3'd2, 1'b1, "R7");
        run_mon(8, 2);

        // R9: truncation by the period, at the 512 fs ratio
        ratio_sel = 2'd2; rep_frames = 12'd3; burst_len = 16'd1000;
        burst_type = 5'h1F; burst_stream = 3'd7;
        do_reset();
        push_data(9, 3, 1000, 1000, 5'h1F, 5'h1F, 3'd7, 1'b1, "R7");
        run_mon(18, 4);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule